// File: doc/BRIEF.md
# Recursive Vertical-Crosswise Unsigned Multiplier

This block multiplies two unsigned N-bit operands and returns the exact 2N-bit product. Each operand is cut into an upper and a lower half. Four half-width products are formed side by side: low×low, high×high and the two cross terms. Each of these comes from an identical multiplier one level down. The recursion stops at a 2×2 cell, which produces its four result bits in three steps. The first step takes the vertical product of the low bits. The second step adds the two crosswise products. The third step takes the vertical product of the high bits together with the carry from the second step.

At every level, a merge adder combines the four sub-products. The low×low and high×high products are concatenated, and the sum of the two cross products, shifted up by N/2, is added to that. A parameter chooses between a purely combinational output and one output register that adds a single cycle of latency. The width must be a power of two of at least 2; any other value stops elaboration.

Top module: `vedic_mult`

## Requirements
- R1: For every pair of unsigned operands, the output equals the exact product a_i × b_i, zero-extended to 2×WIDTH bits.
- R2: When either operand is zero, the product is zero.
- R3: When one operand equals 1, the product equals the other operand zero-extended.
- R4: All-ones times all-ones gives 2^(2N) − 2^(N+1) + 1, so the top bit is set and bit 0 is set.
- R5: With REG_OUT=1, the product of the operands present at a rising clock edge appears after that edge and holds until the next edge. With REG_OUT=0, the product follows the operands within the same cycle.
- R6: With REG_OUT=1, while rst_ni is low the product output is zero, regardless of the operands.
- R7: Operands with only the upper half set in one and only the lower half set in the other give the cross product shifted left by WIDTH/2. This exercises a single cross term of the merge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the optional output register |
| rst_ni | input | 1 | Active-low asynchronous reset of the output register |
| a_i | input | WIDTH | Unsigned multiplicand |
| b_i | input | WIDTH | Unsigned multiplier |
| prod_o | output | 2*WIDTH | Unsigned product |

## Verification
The assertions assume the operands are settled at each rising edge. In registered mode they also compare against operands sampled one edge earlier, and only from the second edge after reset release onward. To stay within this, the stimulus changes operands only on falling edges, and it holds operands steady across reset. Checks on the combinational instance are made a short delay after each change. Checks on the registered instance are made half a cycle after the capturing edge.

// File: rtl/vmul_pkg.sv
package vmul_pkg;
  function automatic bit is_pow2(input int unsigned v);
    return (v >= 2) && ((v & (v - 1)) == 0);
  endfunction
endpackage

// File: rtl/vmul_leaf2.sv
module vmul_leaf2 (
  input  logic [1:0] a_i,
  input  logic [1:0] b_i,
  output logic [3:0] p_o
);
  logic v_lo, v_hi, x_0, x_1, x_c;

  always_comb begin
    v_lo = a_i[0] & b_i[0];           // step one: vertical low
    x_0  = a_i[1] & b_i[0];           // step two: crosswise pair
    x_1  = a_i[0] & b_i[1];
    x_c  = x_0 & x_1;                 // carry out of step two
    v_hi = a_i[1] & b_i[1];           // step three: vertical high + carry
    p_o  = {v_hi & x_c, v_hi ^ x_c, x_0 ^ x_1, v_lo};
  end
endmodule

// File: rtl/vmul_merge.sv
module vmul_merge #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0]   ll_i,
  input  logic [W-1:0]   lh_i,
  input  logic [W-1:0]   hl_i,
  input  logic [W-1:0]   hh_i,
  output logic [2*W-1:0] p_o
);
  localparam int unsigned H  = W / 2;
  localparam int unsigned PW = 2 * W;

  logic [W:0]    mid;
  logic [PW-1:0] mid_ext;

  always_comb begin
    mid     = {1'b0, lh_i} + {1'b0, hl_i};
    mid_ext = PW'(mid) << H;
    p_o     = {hh_i, ll_i} + mid_ext;
  end
endmodule

// File: rtl/vmul_node.sv
module vmul_node #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  output logic [2*W-1:0] p_o
);
  localparam int unsigned H = W / 2;

  if (W == 2) begin : g_leaf
    vmul_leaf2 u_leaf (.a_i(a_i), .b_i(b_i), .p_o(p_o));
  end else begin : g_split
    logic [W-1:0] ll, lh, hl, hh;

    vmul_node #(.W(H)) u_ll (.a_i(a_i[H-1:0]), .b_i(b_i[H-1:0]), .p_o(ll));
    vmul_node #(.W(H)) u_lh (.a_i(a_i[H-1:0]), .b_i(b_i[W-1:H]), .p_o(lh));
    vmul_node #(.W(H)) u_hl (.a_i(a_i[W-1:H]), .b_i(b_i[H-1:0]), .p_o(hl));
    vmul_node #(.W(H)) u_hh (.a_i(a_i[W-1:H]), .b_i(b_i[W-1:H]), .p_o(hh));

    vmul_merge #(.W(W)) u_merge (
      .ll_i(ll), .lh_i(lh), .hl_i(hl), .hh_i(hh), .p_o(p_o)
    );
  end
endmodule

// File: rtl/vedic_mult.sv
module vedic_mult #(
  parameter int unsigned WIDTH   = 16,
  parameter bit          REG_OUT = 1'b1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [WIDTH-1:0]   a_i,
  input  logic [WIDTH-1:0]   b_i,
  output logic [2*WIDTH-1:0] prod_o
);
  localparam int unsigned PW = 2 * WIDTH;

  if (!vmul_pkg::is_pow2(WIDTH)) begin : g_bad_width
    $error("vedic_mult: WIDTH must be a power of two >= 2");
  end

  logic [PW-1:0] prod_c;

  vmul_node #(.W(WIDTH)) u_root (.a_i(a_i), .b_i(b_i), .p_o(prod_c));

  if (REG_OUT) begin : g_reg
    logic [PW-1:0] prod_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prod_q <= '0;
      else         prod_q <= prod_c;
    end
    assign prod_o = prod_q;
  end else begin : g_comb
    assign prod_o = prod_c;
  end
endmodule

// File: rtl/vedic_mult_chk.sv
module vedic_mult_chk #(
  parameter int unsigned WIDTH   = 16,
  parameter bit          REG_OUT = 1'b1
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [WIDTH-1:0]   a_i,
  input logic [WIDTH-1:0]   b_i,
  input logic [2*WIDTH-1:0] prod_o
);
  localparam int unsigned PW = 2 * WIDTH;

  logic [PW-1:0] ref_w;
  logic          zero_w, one_w;
  logic          primed_q;

  assign ref_w  = PW'(a_i) * PW'(b_i);
  assign zero_w = (a_i == '0) || (b_i == '0);
  assign one_w  = (a_i == WIDTH'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) primed_q <= 1'b0;
    else         primed_q <= 1'b1;
  end

  if (REG_OUT) begin : g_reg
    assert_exact_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      primed_q |-> prod_o == $past(ref_w));
    assert_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (primed_q && $past(zero_w)) |-> prod_o == '0);
    assert_one_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (primed_q && $past(one_w)) |-> prod_o == PW'($past(b_i)));
    assert_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (primed_q && $stable(a_i) && $stable(b_i)) |=> $stable(prod_o));
    always @(negedge clk_i)
      if (!rst_ni) assert_reset_zero_R6: assert (prod_o == '0);
  end else begin : g_comb
    assert_exact_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      prod_o == ref_w);
    assert_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      zero_w |-> prod_o == '0);
    assert_one_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      one_w |-> prod_o == PW'(b_i));
    assert_follow_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (primed_q && $stable(a_i) && $stable(b_i)) |-> $stable(prod_o));
  end
endmodule

bind vedic_mult vedic_mult_chk #(.WIDTH(WIDTH), .REG_OUT(REG_OUT)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .a_i(a_i), .b_i(b_i), .prod_o(prod_o)
);

// File: tb/vedic_mult_tb_top.sv
module vedic_mult_tb_top;
  localparam int unsigned WR = 16;
  localparam int unsigned WC = 8;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [WR-1:0]   a_r = '0, b_r = '0;
  logic [WC-1:0]   a_c = '0, b_c = '0;
  logic [2*WR-1:0] p_r;
  logic [2*WC-1:0] p_c;
  int              total = 0, bad = 0;
  longint unsigned prev_r = 0;

  always #10 clk = ~clk;  // 50 MHz

  vedic_mult #(.WIDTH(WR), .REG_OUT(1'b1)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .a_i(a_r), .b_i(b_r), .prod_o(p_r));
  vedic_mult #(.WIDTH(WC), .REG_OUT(1'b0)) dut_c_i (
    .clk_i(clk), .rst_ni(rst_n), .a_i(a_c), .b_i(b_c), .prod_o(p_c));

  task automatic chk(input bit ok, input string req, input longint unsigned act,
                     input longint unsigned exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the next falling edge.
  task automatic step(input logic [WR-1:0] a, input logic [WR-1:0] b, input string req);
    longint unsigned er, ec;
    er = longint'(a) * longint'(b);
    ec = longint'(a[WC-1:0]) * longint'(b[WC-1:0]);
    a_r = a; b_r = b; a_c = a[WC-1:0]; b_c = b[WC-1:0];
    #1;
    chk(64'(p_c) == ec, {req, " comb"}, 64'(p_c), ec);
    chk(64'(p_r) == prev_r, "R5 latency", 64'(p_r), prev_r);
    @(negedge clk);
    chk(64'(p_r) == er, {req, " reg"}, 64'(p_r), er);
    prev_r = er;
  endtask

  initial begin
    #(200000 * 20);
    bad++; total++;
    $display("FAIL watchdog act=0 exp=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    a_r = 16'h1234; b_r = 16'h00ff;
    repeat (3) @(negedge clk);
    chk(p_r == '0, "R6 reset", 64'(p_r), 0);
    rst_n = 1'b1;
    @(negedge clk);
    prev_r = 64'h1234 * 64'hff;
    chk(64'(p_r) == prev_r, "R5 first", 64'(p_r), prev_r);

    step(16'h0000, 16'hbeef, "R2 zero a");
    step(16'hbeef, 16'h0000, "R2 zero b");
    step(16'h0001, 16'hc3a5, "R3 one a");
    step(16'h7e5b, 16'h0001, "R3 one b");
    step(16'hffff, 16'hffff, "R4 all ones");
    step(16'h00ff, 16'hffff, "R4 mixed ones");
    step(16'hab00, 16'h00cd, "R7 cross hl");
    step(16'h0012, 16'h3400, "R7 cross lh");
    step(16'h0003, 16'h0003, "R1 leaf 3x3");
    step(16'h8000, 16'h8000, "R1 top bits");
    step(16'h0f0f, 16'h0f0f, "R5 repeat1");
    step(16'h0f0f, 16'h0f0f, "R5 repeat2");
    for (int i = 0; i < 300; i++)
      step(16'($urandom), 16'($urandom), "R1 random");

    a_r = 16'hffff; b_r = 16'hffff;
    #2 rst_n = 1'b0;
    #1 chk(p_r == '0, "R6 async reset", 64'(p_r), 0);
    @(negedge clk);
    chk(p_r == '0, "R6 held", 64'(p_r), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule